// File: doc/BRIEF.md
# Password Retry Lockout Counter

This block counts failed password attempts and decides, at the start of each access, whether the access may go ahead. It keeps a programmable attempt limit, a wrapping attempt counter and a small control field. The control field holds an enable bit, a clear-on-success bit and a two-bit lockout policy. The password comparison itself is done elsewhere. This block only receives a strobe with a correct or wrong flag once that comparison has finished.

When an access begins, the access logic pulses a check strobe. If counting is enabled and the counter equals the limit, the block raises one of two flags. The policy field picks which one: either every further access is refused, or only configuration operations are allowed. A wrong password advances the counter. A correct password either clears the counter or leaves it unchanged. A configuration write port reloads the limit, the counter and the control field in one clock. A bulk-load input forces all three to all ones or all zeros.

Top module: `retry_lockout`

## Requirements
- R1: After reset the limit, the counter and the control field are zero and both `denyAll` and `cfgOnly` are 0.
- R2: The flags take a new value only at the clock edge where `checkStb` is high. From the following cycle they hold that value until the next check. The check uses the register values from before any update made at the same edge.
- R3: At a check with counting enabled and counter equal to limit, policy `10` (`cfgWrCtl[3:2]` = ua1,ua2) sets `denyAll`=1 and `cfgOnly`=0. Policy codes `00`, `01` and `11` set `cfgOnly`=1 and `denyAll`=0. The two flags are never high together.
- R4: At a check where the counter differs from the limit, both flags become 0.
- R5: When the enable bit (`cfgWrCtl[0]`) is 0, a check always yields both flags 0, even when the counter equals the limit.
- R6: With counting enabled, a `resultStb` with `pwOk`=0 adds one to the counter, modulo 2^CNT_W. A counter above the limit therefore wraps through zero before it can reach the limit.
- R7: With counting enabled, a `resultStb` with `pwOk`=1 clears the counter when the clear-on-success bit (`cfgWrCtl[1]`) is 1, and leaves it unchanged when that bit is 0.
- R8: `cfgWrStb` loads the limit, the counter and the control field in one clock. In that same cycle it takes priority over any password result.
- R9: `massStb` sets the limit, the counter and every control bit to `massVal` in one clock. It takes priority over a configuration write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| checkStb | input | 1 | Start-of-access lockout check |
| resultStb | input | 1 | Password comparison finished |
| pwOk | input | 1 | 1 = password correct, 0 = wrong (valid with `resultStb`) |
| cfgWrStb | input | 1 | Load limit, counter and control field |
| cfgWrLimit | input | CNT_W | New attempt limit |
| cfgWrCount | input | CNT_W | New attempt counter value |
| cfgWrCtl | input | 4 | [3] ua1, [2] ua2, [1] clear-on-success, [0] enable |
| massStb | input | 1 | Bulk load of all registers |
| massVal | input | 1 | Bulk value: 1 = all ones, 0 = all zeros |
| denyAll | output | 1 | Limit reached: refuse every access |
| cfgOnly | output | 1 | Limit reached: allow configuration operations only |

## Verification
The bench builds the block with CNT_W = 3, so each register has eight values. This makes it possible to sweep every limit/counter pair, with zero to eight wrong attempts on each pair. That sweep covers the counter reaching the limit from below, passing it, and wrapping round from above. The expected flags come from modular arithmetic on the loaded values and a rotating policy code. Further sweeps over the limit/counter pairs cover clearing and keeping the counter on success, and the disabled case. Short directed sequences cover the same-edge priorities, the bulk loads and flag holding.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

  // Policy code (ua1,ua2) that refuses every access once the limit is hit.
  localparam logic [1:0] POL_DENY_ALL = 2'b10;
  localparam int CTL_W = 4;

  typedef struct packed {
    logic loadCfg;
    logic massLoad;
    logic massVal;
    logic incCnt;
    logic clrCnt;
    logic sample;
    logic denyNext;
    logic cfgNext;
  } rlcStrobes_t;

endpackage

// File: rtl/rlc_ctrl.sv
module rlc_ctrl
  import rlc_pkg::*;
(
  input  logic        checkStb,
  input  logic        resultStb,
  input  logic        pwOk,
  input  logic        cfgWrStb,
  input  logic        massStb,
  input  logic        massVal,
  input  logic        enQ,
  input  logic        clrQ,
  input  logic [1:0]  polQ,
  input  logic        hit,
  output rlcStrobes_t stb
);

  logic regBusy;
  logic lockHit;

  always_comb begin
    regBusy      = massStb | cfgWrStb;
    lockHit      = enQ & hit;
    stb.massLoad = massStb;
    stb.massVal  = massVal;
    stb.loadCfg  = cfgWrStb & ~massStb;
    stb.incCnt   = resultStb & ~pwOk & enQ & ~regBusy;
    stb.clrCnt   = resultStb & pwOk & enQ & clrQ & ~regBusy;
    stb.sample   = checkStb;
    stb.denyNext = lockHit & (polQ == POL_DENY_ALL);
    stb.cfgNext  = lockHit & (polQ != POL_DENY_ALL);
  end

endmodule

// File: rtl/rlc_dpath.sv
module rlc_dpath
  import rlc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  rlcStrobes_t        stb,
  input  logic [CNT_W-1:0]   cfgWrLimit,
  input  logic [CNT_W-1:0]   cfgWrCount,
  input  logic [CTL_W-1:0]   cfgWrCtl,
  output logic [CNT_W-1:0]   limQ,
  output logic [CNT_W-1:0]   cntQ,
  output logic               enQ,
  output logic               clrQ,
  output logic [1:0]         polQ,
  output logic               hit,
  output logic               denyAll,
  output logic               cfgOnly
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CTL_W-1:0] ctlQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limQ <= '0;
      cntQ <= '0;
      ctlQ <= '0;
    end else if (stb.massLoad) begin
      limQ <= {CNT_W{stb.massVal}};
      cntQ <= {CNT_W{stb.massVal}};
      ctlQ <= {CTL_W{stb.massVal}};
    end else if (stb.loadCfg) begin
      limQ <= cfgWrLimit;
      cntQ <= cfgWrCount;
      ctlQ <= cfgWrCtl;
    end else if (stb.incCnt) begin
      cntQ <= cntQ + CNT_ONE;
    end else if (stb.clrCnt) begin
      cntQ <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      denyAll <= 1'b0;
      cfgOnly <= 1'b0;
    end else if (stb.sample) begin
      denyAll <= stb.denyNext;
      cfgOnly <= stb.cfgNext;
    end
  end

  assign enQ  = ctlQ[0];
  assign clrQ = ctlQ[1];
  assign polQ = ctlQ[3:2];
  assign hit  = (limQ == cntQ);

endmodule

// File: rtl/retry_lockout.sv
module retry_lockout
  import rlc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             checkStb,
  input  logic             resultStb,
  input  logic             pwOk,
  input  logic             cfgWrStb,
  input  logic [CNT_W-1:0] cfgWrLimit,
  input  logic [CNT_W-1:0] cfgWrCount,
  input  logic [3:0]       cfgWrCtl,
  input  logic             massStb,
  input  logic             massVal,
  output logic             denyAll,
  output logic             cfgOnly
);

  rlcStrobes_t      stb;
  logic [CNT_W-1:0] limQ;
  logic [CNT_W-1:0] cntQ;
  logic             enQ;
  logic             clrQ;
  logic [1:0]       polQ;
  logic             hit;

  rlc_ctrl u_ctrl (
    .checkStb (checkStb),
    .resultStb(resultStb),
    .pwOk     (pwOk),
    .cfgWrStb (cfgWrStb),
    .massStb  (massStb),
    .massVal  (massVal),
    .enQ      (enQ),
    .clrQ     (clrQ),
    .polQ     (polQ),
    .hit      (hit),
    .stb      (stb)
  );

  rlc_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cfgWrLimit(cfgWrLimit),
    .cfgWrCount(cfgWrCount),
    .cfgWrCtl  (cfgWrCtl),
    .limQ      (limQ),
    .cntQ      (cntQ),
    .enQ       (enQ),
    .clrQ      (clrQ),
    .polQ      (polQ),
    .hit       (hit),
    .denyAll   (denyAll),
    .cfgOnly   (cfgOnly)
  );

endmodule

// File: rtl/rlc_checker.sv
module rlc_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             checkStb,
  input logic             resultStb,
  input logic             pwOk,
  input logic             cfgWrStb,
  input logic [CNT_W-1:0] cfgWrCount,
  input logic             massStb,
  input logic [CNT_W-1:0] limQ,
  input logic [CNT_W-1:0] cntQ,
  input logic             enQ,
  input logic             clrQ,
  input logic [1:0]       polQ,
  input logic             denyAll,
  input logic             cfgOnly
);

  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(denyAll && cfgOnly));

  a_r3_deny_policy: assert property (@(posedge clk) disable iff (!rstN)
    (checkStb && enQ && limQ == cntQ && polQ == 2'b10) |=> denyAll);

  a_r4_no_lock: assert property (@(posedge clk) disable iff (!rstN)
    (checkStb && (!enQ || limQ != cntQ)) |=> (!denyAll && !cfgOnly));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !checkStb |=> ($stable(denyAll) && $stable(cfgOnly)));

  a_r6_wrong_inc: assert property (@(posedge clk) disable iff (!rstN)
    (resultStb && !pwOk && enQ && !cfgWrStb && !massStb)
      |=> cntQ == CNT_W'($past(cntQ) + 1'b1));

  a_r7_ok_clear: assert property (@(posedge clk) disable iff (!rstN)
    (resultStb && pwOk && enQ && clrQ && !cfgWrStb && !massStb) |=> cntQ == '0);

  a_r8_cfg_load: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrStb && !massStb) |=> cntQ == $past(cfgWrCount));

endmodule

bind retry_lockout rlc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .checkStb  (checkStb),
  .resultStb (resultStb),
  .pwOk      (pwOk),
  .cfgWrStb  (cfgWrStb),
  .cfgWrCount(cfgWrCount),
  .massStb   (massStb),
  .limQ      (limQ),
  .cntQ      (cntQ),
  .enQ       (enQ),
  .clrQ      (clrQ),
  .polQ      (polQ),
  .denyAll   (denyAll),
  .cfgOnly   (cfgOnly)
);

// File: tb/sim_retry_lockout.sv
`timescale 1ns/1ps
module sim_retry_lockout;

  localparam int W = 3;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         checkStb = 1'b0;
  logic         resultStb = 1'b0;
  logic         pwOk = 1'b0;
  logic         cfgWrStb = 1'b0;
  logic [W-1:0] cfgWrLimit = '0;
  logic [W-1:0] cfgWrCount = '0;
  logic [3:0]   cfgWrCtl = '0;
  logic         massStb = 1'b0;
  logic         massVal = 1'b0;
  logic         denyAll;
  logic         cfgOnly;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  retry_lockout #(.CNT_W(W)) u0 (.*);

  task automatic expectFlags(input string req, input logic expDeny, input logic expCfg);
    testsRun++;
    if (denyAll !== expDeny || cfgOnly !== expCfg) begin
      testsFailed++;
      $display("FAIL %s: deny/cfg actual %b%b expected %b%b", req, denyAll, cfgOnly, expDeny, expCfg);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic cfgWrite(input int lim, input int cnt, input logic [3:0] ctl);
    cfgWrStb = 1'b1; cfgWrLimit = W'(lim); cfgWrCount = W'(cnt); cfgWrCtl = ctl;
    @(negedge clk);
    cfgWrStb = 1'b0;
  endtask

  task automatic result(input logic ok);
    resultStb = 1'b1; pwOk = ok;
    @(negedge clk);
    resultStb = 1'b0;
  endtask

  task automatic doCheck(input string req, input logic expDeny, input logic expCfg);
    checkStb = 1'b1;
    @(negedge clk);
    checkStb = 1'b0;
    expectFlags(req, expDeny, expCfg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expectFlags("R1 reset flags", 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    expectFlags("R1 after release", 1'b0, 1'b0);
    // Reset state: limit 0 == counter 0 but enable 0 -> no lockout.
    doCheck("R1 reset regs", 1'b0, 1'b0);

    // R6/R3/R4: every limit/counter pair, 0..N wrong attempts, rotating policy.
    for (int lim = 0; lim < N; lim++) begin
      for (int cnt = 0; cnt < N; cnt++) begin
        for (int k = 0; k <= N; k++) begin
          logic [1:0] pol;
          logic hitE;
          pol = 2'((lim * 3 + cnt + k) % 4);
          cfgWrite(lim, cnt, {pol, 1'b0, 1'b1});
          for (int j = 0; j < k; j++) result(1'b0);
          hitE = ((cnt + k) % N) == lim;
          doCheck(hitE ? "R3 R6 lock sweep" : "R4 R6 no-lock sweep",
                  hitE && pol == 2'b10, hitE && pol != 2'b10);
        end
      end
    end

    // R7: correct password with clear bit set and clear bit clear.
    for (int lim = 0; lim < N; lim++) begin
      for (int cnt = 0; cnt < N; cnt++) begin
        cfgWrite(lim, cnt, 4'b0111);
        result(1'b1);
        doCheck("R7 clear on ok", 1'b0, lim == 0);
        cfgWrite(lim, cnt, 4'b1001);
        result(1'b1);
        doCheck("R7 keep on ok", lim == cnt, 1'b0);
      end
    end

    // R5: disabled counting never locks.
    for (int v = 0; v < N; v++) begin
      cfgWrite(v, v, 4'b1010);
      doCheck("R5 disabled equal", 1'b0, 1'b0);
      result(1'b0);
      doCheck("R5 disabled after wrong", 1'b0, 1'b0);
    end

    // R8: config write wins over a wrong result in the same cycle.
    cfgWrStb = 1'b1; cfgWrLimit = 3'd4; cfgWrCount = 3'd4; cfgWrCtl = 4'b1001;
    resultStb = 1'b1; pwOk = 1'b0;
    @(negedge clk);
    cfgWrStb = 1'b0; resultStb = 1'b0;
    doCheck("R8 cfg over result", 1'b1, 1'b0);

    // R9: bulk ones beats a simultaneous config write; policy 11 -> cfgOnly.
    massStb = 1'b1; massVal = 1'b1;
    cfgWrStb = 1'b1; cfgWrLimit = 3'd2; cfgWrCount = 3'd5; cfgWrCtl = 4'b0000;
    @(negedge clk);
    massStb = 1'b0; cfgWrStb = 1'b0;
    doCheck("R9 mass ones", 1'b0, 1'b1);
    // Clear-on-success was set to one by the bulk load.
    result(1'b1);
    doCheck("R9 mass ones clr bit", 1'b0, 1'b0);
    massStb = 1'b1; massVal = 1'b0;
    @(negedge clk);
    massStb = 1'b0;
    doCheck("R9 mass zeros", 1'b0, 1'b0);

    // R2: check sees values from before a same-edge update, then flags hold.
    cfgWrite(1, 0, 4'b1001);
    checkStb = 1'b1; resultStb = 1'b1; pwOk = 1'b0;
    @(negedge clk);
    checkStb = 1'b0; resultStb = 1'b0;
    expectFlags("R2 pre-update sample", 1'b0, 1'b0);
    doCheck("R2 lock after wrong", 1'b1, 1'b0);
    result(1'b0);
    repeat (3) @(negedge clk);
    expectFlags("R2 flags held", 1'b1, 1'b0);
    doCheck("R2 recheck past limit", 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule